// File: doc/BRIEF.md
# Two-Port Memory with Mailbox Interrupts

This block is a synchronous memory with two fully independent access ports, called A (left) and B (right). Each port has a chip enable, an output enable, a write select, an address and an 18-bit data path. Either port may read or write any word of the array on any clock edge. Reads are registered and take one cycle.

The two highest words of the array also work as mailboxes, so that the agents on the two ports can signal each other. Port A's mailbox is the second-highest word. Port B's mailbox is the highest word. When one port writes the other port's mailbox, the active-low interrupt output of the receiving port goes low. The receiving port clears that interrupt by accessing its own mailbox with chip enable and output enable both active. The mailbox words are still ordinary storage, so the message written there can be read back from either port. A `mbox_en` input turns the mailbox function off. When it is off, the top two words are plain memory and both interrupts stay inactive.

Each interrupt is held by a two-state machine. IDLE drives the output high and PEND drives it low. There are three transitions. SET goes from IDLE to PEND when the partner port writes the mailbox. CLEAR goes from PEND to IDLE when the owning port accesses its mailbox with no SET in the same cycle. DISABLE forces any state back to IDLE while `mbox_en` is low. A `HALF` parameter halves the usable depth: the top address bit is then ignored and the mailboxes move down to the top two words of the smaller array.

Top module: `dpram_mailbox`

## Requirements
- R1: On a clock edge where a port has `ce`=1 and `wr`=1, that port's `wdata` is stored at its address.
- R2: On a clock edge where a port has `ce`=1, `oe`=1 and `wr`=0, that port's `rdata` takes the word at its address. The new value is visible after that edge. If the other port writes the same word on the same edge, the read returns the contents from before that write.
- R3: A port with `ce`=0 stores nothing. A port's `rdata` keeps its value on every edge where that port does not read.
- R4: When both ports write the same word on the same edge, port A's data is the value that is kept.
- R5: With `mbox_en`=1, a port B write to address DEPTH-2 drives `a_irq_n` low after that edge.
- R6: A port A access to address DEPTH-2 with `a_ce`=1 and `a_oe`=1 drives `a_irq_n` high after that edge. `a_wr` may be either value.
- R7: With `mbox_en`=1, a port A write to address DEPTH-1 drives `b_irq_n` low. A port B access to DEPTH-1 with `b_ce`=1 and `b_oe`=1 drives it high again.
- R8: When a SET and a CLEAR of the same interrupt fall on the same edge, the interrupt stays or becomes active (low).
- R9: A mailbox word holds the 18-bit message that was written to it, and that word can be read from either port.
- R10: While `mbox_en`=0, both interrupts are driven high after the next edge, including one that was pending, and writes to the top two words raise nothing.
- R11: With `HALF`=1, the top address bit is ignored. DEPTH becomes 2**(ADDR_W-1), so the mailboxes sit at 2**(ADDR_W-1)-2 for A and 2**(ADDR_W-1)-1 for B.
- R12: During reset, both interrupts are high and both `rdata` outputs are zero.
- R13: A port writing its own mailbox with `oe`=0 raises neither interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mbox_en | input | 1 | Enables the mailbox interrupt function |
| a_ce | input | 1 | Port A chip enable |
| a_oe | input | 1 | Port A output enable |
| a_wr | input | 1 | Port A write select (1 = write, 0 = read) |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_ce | input | 1 | Port B chip enable |
| b_oe | input | 1 | Port B output enable |
| b_wr | input | 1 | Port B write select (1 = write, 0 = read) |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
The bench builds two copies of the block. Both use `ADDR_W`=4 and the full 18-bit data width. The first copy has `HALF`=0 and the second has `HALF`=1, which gives arrays of 16 and 8 words. At these sizes every address can be written and read back from both ports with arithmetic data patterns. The mailboxes sit at addresses 14/15 and 6/7, close enough to the rest of the array that aliasing of the ignored top bit lands directly on a mailbox. Every ordering of SET, CLEAR and DISABLE can then be driven in a handful of cycles.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    // State of one mailbox interrupt
    typedef enum logic {
        MB_IDLE = 1'b0,
        MB_PEND = 1'b1
    } mb_state_t;

endpackage

// File: rtl/dpm_array.sv
module dpm_array #(
    parameter int AW     = 4,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic              a_rd,
    input  logic [AW-1:0]     a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_we,
    input  logic              b_rd,
    input  logic [AW-1:0]     b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Port B is written first so a same-word port A write overrides it.
    always_ff @(posedge clk) begin
        if (b_we) mem[b_addr] <= b_wdata;
        if (a_we) mem[a_addr] <= a_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_rd) a_rdata <= mem[a_addr];
            if (b_rd) b_rdata <= mem[b_addr];
        end
    end

    // R4
    left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && b_we && a_addr == b_addr) |=> mem[$past(a_addr)] == $past(a_wdata));

    // R3
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_rd |=> $stable(a_rdata));

    // R3
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_rd |=> $stable(b_rdata));

endmodule

// File: rtl/dpm_mbox_flag.sv
module dpm_mbox_flag
    import dpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);

    mb_state_t state_q, state_d;

    // Next state: SET, CLEAR, DISABLE
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = MB_IDLE;
        end else begin
            unique case (state_q)
                MB_IDLE: if (set_i)  state_d = MB_PEND;
                MB_PEND: if (!set_i && clr_i) state_d = MB_IDLE;
                default: state_d = MB_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MB_IDLE;
        else        state_q <= state_d;
    end

    // Output: decoded from the state register only
    always_comb begin
        irq_n_o = (state_q != MB_PEND);
    end

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && set_i) |=> !irq_n_o);

    // R6
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && clr_i && !set_i) |=> irq_n_o);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && set_i && clr_i) |=> !irq_n_o);

    // R10
    flag_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> irq_n_o);

endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 18,
    parameter bit HALF   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mbox_en,
    input  logic              a_ce,
    input  logic              a_oe,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq_n,
    input  logic              b_ce,
    input  logic              b_oe,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq_n
);

    localparam int EFF_W = HALF ? ADDR_W - 1 : ADDR_W;
    localparam int DEPTH = 1 << EFF_W;
    localparam logic [EFF_W-1:0] A_MBOX = EFF_W'(DEPTH - 2);
    localparam logic [EFF_W-1:0] B_MBOX = EFF_W'(DEPTH - 1);

    logic [EFF_W-1:0] a_eff, b_eff;

    assign a_eff = a_addr[EFF_W-1:0];
    assign b_eff = b_addr[EFF_W-1:0];

    generate
        if (HALF) begin : g_half
            logic unused_top;
            assign unused_top = a_addr[ADDR_W-1] ^ b_addr[ADDR_W-1];
        end
    endgenerate

    logic a_we, a_rd, b_we, b_rd;

    assign a_we = a_ce && a_wr;
    assign a_rd = a_ce && a_oe && !a_wr;
    assign b_we = b_ce && b_wr;
    assign b_rd = b_ce && b_oe && !b_wr;

    dpm_array #(
        .AW     (EFF_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (a_we),
        .a_rd    (a_rd),
        .a_addr  (a_eff),
        .a_wdata (a_wdata),
        .a_rdata (a_rdata),
        .b_we    (b_we),
        .b_rd    (b_rd),
        .b_addr  (b_eff),
        .b_wdata (b_wdata),
        .b_rdata (b_rdata)
    );

    logic a_set, a_clr, b_set, b_clr;

    assign a_set = b_we && (b_eff == A_MBOX);
    assign a_clr = a_ce && a_oe && (a_eff == A_MBOX);
    assign b_set = a_we && (a_eff == B_MBOX);
    assign b_clr = b_ce && b_oe && (b_eff == B_MBOX);

    dpm_mbox_flag u_flag_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (mbox_en),
        .set_i   (a_set),
        .clr_i   (a_clr),
        .irq_n_o (a_irq_n)
    );

    dpm_mbox_flag u_flag_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (mbox_en),
        .set_i   (b_set),
        .clr_i   (b_clr),
        .irq_n_o (b_irq_n)
    );

    // R13
    own_mbox_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_irq_n && b_irq_n && !b_ce && a_we && !a_oe && a_eff == A_MBOX) |=> (a_irq_n && b_irq_n));

endmodule

// File: tb/tb_dpram_mailbox.sv
module tb_dpram_mailbox;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 18;
    localparam int N  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mbox_en = 1'b0;
    logic a_ce = 0, a_oe = 0, a_wr = 0;
    logic b_ce = 0, b_oe = 0, b_wr = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata, h_a_rdata, h_b_rdata;
    logic a_irq_n, b_irq_n, h_a_irq_n, h_b_irq_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW), .HALF(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
        .a_ce(a_ce), .a_oe(a_oe), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq_n(a_irq_n),
        .b_ce(b_ce), .b_oe(b_oe), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq_n(b_irq_n)
    );

    dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW), .HALF(1'b1)) dut_half (
        .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
        .a_ce(a_ce), .a_oe(a_oe), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(h_a_rdata), .a_irq_n(h_a_irq_n),
        .b_ce(b_ce), .b_oe(b_oe), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(h_b_rdata), .b_irq_n(h_b_irq_n)
    );

    function automatic logic [DW-1:0] pat_a(input int i);
        return DW'(i * 32'h1357 + 32'h2A5);
    endfunction

    function automatic logic [DW-1:0] pat_b(input int i);
        return ~pat_a(i);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        a_ce = 0; a_oe = 0; a_wr = 0;
        b_ce = 0; b_oe = 0; b_wr = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic a_op(input logic oe, input logic wr, input int ad, input logic [DW-1:0] d);
        a_ce = 1; a_oe = oe; a_wr = wr; a_addr = AW'(ad); a_wdata = d;
    endtask

    task automatic b_op(input logic oe, input logic wr, input int ad, input logic [DW-1:0] d);
        b_ce = 1; b_oe = oe; b_wr = wr; b_addr = AW'(ad); b_wdata = d;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        repeat (3) step();
        // R12: reset values
        chk("R12 a_irq_n", 32'(a_irq_n), 1);
        chk("R12 b_irq_n", 32'(b_irq_n), 1);
        chk("R12 a_rdata", 32'(a_rdata), 0);
        chk("R12 b_rdata", 32'(b_rdata), 0);
        rst_n = 1;
        step();

        // R1, R10: port A fills the array with the mailbox function off
        for (int i = 0; i < N; i++) begin
            idle(); a_op(0, 1, i, pat_a(i)); step();
            chk("R10 a_irq_n off", 32'(a_irq_n), 1);
            chk("R10 b_irq_n off", 32'(b_irq_n), 1);
        end
        // R2: port B reads every word back
        for (int i = 0; i < N; i++) begin
            idle(); b_op(1, 0, i, '0); step();
            chk("R1 R2 b read", 32'(b_rdata), 32'(pat_a(i)));
        end
        // R2: port A reads a word while port B overwrites it (old data)
        for (int i = 0; i < N; i++) begin
            idle(); b_op(0, 1, i, pat_b(i)); a_op(1, 0, i, '0); step();
            chk("R2 read-before-write", 32'(a_rdata), 32'(pat_a(i)));
        end
        for (int i = 0; i < N; i++) begin
            idle(); a_op(1, 0, i, '0); step();
            chk("R1 a read new", 32'(a_rdata), 32'(pat_b(i)));
        end
        held = a_rdata;

        // R3: disabled port stores nothing, rdata holds
        idle(); a_ce = 0; a_wr = 1; a_addr = 3; a_wdata = 18'h15555; a_oe = 1; step();
        chk("R3 a_rdata hold ce=0", 32'(a_rdata), 32'(held));
        idle(); a_op(0, 0, 4, '0); step();
        chk("R3 a_rdata hold oe=0", 32'(a_rdata), 32'(held));
        idle(); b_op(1, 0, 3, '0); step();
        chk("R3 no write when ce=0", 32'(b_rdata), 32'(pat_b(3)));

        // R4: same-word collision, port A wins
        idle(); a_op(0, 1, 6, 18'h00111); b_op(0, 1, 6, 18'h00222); step();
        idle(); b_op(1, 0, 6, '0); step();
        chk("R4 left wins", 32'(b_rdata), 32'h111);

        // Mailbox function on: A mailbox 14, B mailbox 15
        mbox_en = 1;
        idle(); step();
        // R13: own mailbox write raises nothing
        idle(); a_op(0, 1, 14, 18'h0ABCD); step();
        chk("R13 a_irq_n", 32'(a_irq_n), 1);
        chk("R13 b_irq_n", 32'(b_irq_n), 1);
        // R5: B writes A's mailbox
        idle(); b_op(0, 1, 14, 18'h2C0DE); step();
        chk("R5 a_irq_n set", 32'(a_irq_n), 0);
        chk("R5 b_irq_n quiet", 32'(b_irq_n), 1);
        // R9: B reads the mailbox, no clear
        idle(); b_op(1, 0, 14, '0); step();
        chk("R9 mailbox word", 32'(b_rdata), 32'h2C0DE);
        chk("R9 a_irq_n stays", 32'(a_irq_n), 0);
        // R6: clear with wr=1 and oe=1
        idle(); a_op(1, 1, 14, 18'h01234); step();
        chk("R6 clear wr=1", 32'(a_irq_n), 1);
        idle(); b_op(0, 1, 14, 18'h3FEED); step();
        chk("R5 set again", 32'(a_irq_n), 0);
        // R8: set and clear on the same edge
        idle(); b_op(0, 1, 14, 18'h00777); a_op(1, 0, 14, '0); step();
        chk("R8 set wins", 32'(a_irq_n), 0);
        chk("R2 R9 a read mailbox", 32'(a_rdata), 32'h3FEED);
        idle(); a_op(1, 0, 14, '0); step();
        chk("R6 clear by read", 32'(a_irq_n), 1);
        chk("R9 a reads message", 32'(a_rdata), 32'h00777);
        // R7: A writes B's mailbox, B clears by reading
        idle(); a_op(0, 1, 15, 18'h1BEEF); step();
        chk("R7 b_irq_n set", 32'(b_irq_n), 0);
        chk("R7 a_irq_n quiet", 32'(a_irq_n), 1);
        idle(); b_op(1, 0, 15, '0); step();
        chk("R7 b_irq_n clear", 32'(b_irq_n), 1);
        chk("R9 b reads message", 32'(b_rdata), 32'h1BEEF);

        // R10: disabling drops a pending interrupt and blocks new ones
        idle(); a_op(0, 1, 15, 18'h00042); step();
        chk("R7 pending", 32'(b_irq_n), 0);
        mbox_en = 0;
        idle(); b_op(0, 1, 14, 18'h00043); step();
        chk("R10 pending dropped", 32'(b_irq_n), 1);
        chk("R10 no set", 32'(a_irq_n), 1);
        idle(); a_op(1, 0, 14, '0); step();
        chk("R10 plain word", 32'(a_rdata), 32'h00043);

        // R11: half-depth copy, mailboxes at 6 and 7, top bit ignored
        mbox_en = 1;
        idle(); step();
        idle(); a_op(0, 1, 15, 18'h2A5A5); step();
        chk("R11 half b_irq_n set", 32'(h_b_irq_n), 0);
        chk("R11 half a_irq_n quiet", 32'(h_a_irq_n), 1);
        idle(); b_op(1, 0, 7, '0); step();
        chk("R11 alias data", 32'(h_b_rdata), 32'h2A5A5);
        chk("R11 half b_irq_n clear", 32'(h_b_irq_n), 1);
        idle(); b_op(0, 1, 6, 18'h00999); step();
        chk("R11 half a_irq_n set", 32'(h_a_irq_n), 0);
        idle(); a_op(1, 0, 14, '0); step();
        chk("R11 clear via alias", 32'(h_a_irq_n), 1);
        chk("R11 alias read", 32'(h_a_rdata), 32'h00999);

        idle(); step();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule